// File: doc/BRIEF.md
# Chained Serial-to-Parallel Shifter with Output Latch

This block turns a serial bit stream into a wide parallel word. A chain of segments shifts the stream in. A second register set holds the last word that was captured, so the parallel outputs stay steady while new bits move through the chain. Each segment has `SEG_BITS` shift stages and `SEG_BITS` holding bits. `SEGMENTS` segments are joined end to end: the last shift stage of one segment feeds the first stage of the next. The parallel width is therefore `SEG_BITS*SEGMENTS`, which is 16 bits with the defaults.

Everything runs on a single system clock. Two enables pick what happens at each rising edge. `adv_en` moves the chain along by one bit, and `cap_en` copies the chain into the holding register. When both are high in the same cycle, the holding register takes the contents from before that cycle's shift, so it stays one shift behind the chain. Each register set has its own asynchronous active-low clear, and that clear overrides its enable. The tap output always shows the final stage of the chain, so further blocks can be hung off it.

Top module: `sipo_latch_chain`

## Requirements
- R1: At a rising clock edge with `adv_en` high, chain stage 0 loads `bit_in` and every stage i>0 loads the old value of stage i-1. The first stage of each segment takes the last stage of the segment before it, so the whole chain acts as one `SEG_BITS*SEGMENTS`-bit shift register.
- R2: At an edge with `adv_en` low, the chain keeps its contents.
- R3: At an edge with `cap_en` high, the holding register loads the chain contents. `word_out[j]` then shows chain stage j, where bit 0 is the stage nearest `bit_in`.
- R4: At an edge with `cap_en` low, `word_out` keeps its value.
- R5: When `adv_en` and `cap_en` are both high at the same edge, `word_out` takes the chain value from before that edge's shift.
- R6: `tap_out` always shows the last chain stage (index `SEG_BITS*SEGMENTS-1`), taken from the chain and never from the holding register.
- R7: While `chain_clr_n` is low, the chain is zero at once and stays zero even when `adv_en` is high at an edge. The holding register is not affected.
- R8: While `hold_clr_n` is low, `word_out` is zero at once and stays zero even when `cap_en` is high at an edge. The chain is not affected.
- R9: After both clears are released, `word_out` is all zeros and `tap_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| chain_clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| hold_clr_n | input | 1 | Asynchronous active-low clear of the holding register |
| bit_in | input | 1 | Serial data into chain stage 0 |
| adv_en | input | 1 | Shift the chain by one bit at this edge |
| cap_en | input | 1 | Copy the chain into the holding register at this edge |
| word_out | output | SEG_BITS*SEGMENTS | Holding register contents |
| tap_out | output | 1 | Last chain stage, used for cascading |

## Verification
Each enable takes effect at the rising edge where it is sampled. `word_out` and `tap_out` show the result of that edge and are read 1 ns after it. Both clears act without waiting for a clock, so the bench reads the outputs 1 ns after a clear falls, before any edge arrives. The bench's model steps once per edge. When both enables are high, it captures the old chain value before it shifts, which matches the one-shift lag.

// File: rtl/sipo_latch_pkg.sv
`timescale 1ns/1ps
package sipo_latch_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_CAP   = 2'b10,
    OP_BOTH  = 2'b11
  } strobe_op_e;

  function automatic strobe_op_e decode_op(input logic adv, input logic cap);
    return strobe_op_e'({cap, adv});
  endfunction

  function automatic logic op_shifts(input strobe_op_e op);
    return (op == OP_SHIFT) || (op == OP_BOTH);
  endfunction

  function automatic logic op_captures(input strobe_op_e op);
    return (op == OP_CAP) || (op == OP_BOTH);
  endfunction

endpackage

// File: rtl/sipo_shift_seg.sv
`timescale 1ns/1ps
module sipo_shift_seg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         adv,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         dout
);

  function automatic logic [W-1:0] advance(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   q <= '0;
    else if (adv) q <= advance(q, din);
  end

  assign dout = q[W-1];

endmodule

// File: rtl/sipo_hold_reg.sv
`timescale 1ns/1ps
module sipo_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/sipo_latch_chain.sv
`timescale 1ns/1ps
module sipo_latch_chain
  import sipo_latch_pkg::*;
#(
  parameter int SEG_BITS = 8,
  parameter int SEGMENTS = 2
) (
  input  logic                         clk,
  input  logic                         chain_clr_n,
  input  logic                         hold_clr_n,
  input  logic                         bit_in,
  input  logic                         adv_en,
  input  logic                         cap_en,
  output logic [SEG_BITS*SEGMENTS-1:0] word_out,
  output logic                         tap_out
);

  localparam int TOTAL = SEG_BITS * SEGMENTS;

  strobe_op_e        op;
  logic              shift_fire;
  logic              cap_fire;
  logic [SEGMENTS:0] link;
  logic [TOTAL-1:0]  chain_q;

  assign op         = decode_op(adv_en, cap_en);
  assign shift_fire = op_shifts(op);
  assign cap_fire   = op_captures(op);
  assign link[0]    = bit_in;

  for (genvar k = 0; k < SEGMENTS; k++) begin : g_seg
    sipo_shift_seg #(.W(SEG_BITS)) u_shift (
      .clk   (clk),
      .clr_n (chain_clr_n),
      .adv   (shift_fire),
      .din   (link[k]),
      .q     (chain_q[k*SEG_BITS +: SEG_BITS]),
      .dout  (link[k+1])
    );

    sipo_hold_reg #(.W(SEG_BITS)) u_hold (
      .clk   (clk),
      .clr_n (hold_clr_n),
      .load  (cap_fire),
      .d     (chain_q[k*SEG_BITS +: SEG_BITS]),
      .q     (word_out[k*SEG_BITS +: SEG_BITS])
    );
  end

  assign tap_out = link[SEGMENTS];

endmodule

// File: rtl/sipo_latch_chain_chk.sv
`timescale 1ns/1ps
module sipo_latch_chain_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         chain_clr_n,
  input logic         hold_clr_n,
  input logic         bit_in,
  input logic         adv_en,
  input logic         cap_en,
  input logic [N-1:0] chain_q,
  input logic [N-1:0] word_out,
  input logic         tap_out
);

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!chain_clr_n)
    adv_en |=> chain_q == {$past(chain_q[N-2:0]), $past(bit_in)}); // R1

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!chain_clr_n)
    !adv_en |=> $stable(chain_q)); // R2

  AST_CAPTURE_OLD: assert property (@(posedge clk) disable iff (!hold_clr_n)
    cap_en |=> word_out == $past(chain_q)); // R3 R5

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!hold_clr_n)
    !cap_en |=> $stable(word_out)); // R4

  AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (!chain_clr_n)
    adv_en |=> tap_out == $past(chain_q[N-2])); // R6

  AST_CHAIN_CLEARED: assert property (@(posedge clk)
    !chain_clr_n |-> (chain_q == '0 && tap_out == 1'b0)); // R7

  AST_WORD_CLEARED: assert property (@(posedge clk)
    !hold_clr_n |-> word_out == '0); // R8

endmodule

bind sipo_latch_chain sipo_latch_chain_chk #(.N(SEG_BITS*SEGMENTS)) u_chk (
  .clk         (clk),
  .chain_clr_n (chain_clr_n),
  .hold_clr_n  (hold_clr_n),
  .bit_in      (bit_in),
  .adv_en      (adv_en),
  .cap_en      (cap_en),
  .chain_q     (chain_q),
  .word_out    (word_out),
  .tap_out     (tap_out)
);

// File: tb/test_sipo_latch_chain.sv
`timescale 1ns/1ps
module test_sipo_latch_chain;

  localparam int SEG_BITS = 8;
  localparam int SEGMENTS = 2;
  localparam int N        = SEG_BITS * SEGMENTS;

  logic         clk = 1'b0;
  logic         chain_clr_n = 1'b0;
  logic         hold_clr_n  = 1'b0;
  logic         bit_in = 1'b0;
  logic         adv_en = 1'b0;
  logic         cap_en = 1'b0;
  logic [N-1:0] word_out;
  logic         tap_out;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_chain = '0;
  logic [N-1:0] m_word  = '0;

  always #2 clk = ~clk;

  sipo_latch_chain #(.SEG_BITS(SEG_BITS), .SEGMENTS(SEGMENTS)) i_sipo_latch_chain (
    .clk(clk), .chain_clr_n(chain_clr_n), .hold_clr_n(hold_clr_n),
    .bit_in(bit_in), .adv_en(adv_en), .cap_en(cap_en),
    .word_out(word_out), .tap_out(tap_out)
  );

  function automatic logic [N-1:0] model_shift(input logic [N-1:0] c, input logic b);
    logic [N-1:0] r;
    for (int i = N-1; i > 0; i--) r[i] = c[i-1];
    r[0] = b;
    return r;
  endfunction

  task automatic check_word(input string req, input logic [N-1:0] exp);
    checks++;
    if (word_out !== exp) begin
      errors++;
      $display("FAIL %s word_out actual=%h expected=%h", req, word_out, exp);
    end
  endtask

  task automatic check_tap(input string req, input logic exp);
    checks++;
    if (tap_out !== exp) begin
      errors++;
      $display("FAIL %s tap_out actual=%b expected=%b", req, tap_out, exp);
    end
  endtask

  task automatic step(input logic sh, input logic cp, input logic b);
    string req;
    @(negedge clk);
    adv_en = sh; cap_en = cp; bit_in = b;
    @(posedge clk);
    if (cp) m_word = m_chain;
    if (sh) m_chain = model_shift(m_chain, b);
    #1;
    req = (sh && cp) ? "R5" : cp ? "R3" : sh ? "R1" : "R2/R4";
    check_word(req, m_word);
    check_tap(sh ? "R6" : "R2", m_chain[N-1]);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chain_clr_n = 1'b1; hold_clr_n = 1'b1;
    #1;
    check_word("R9", '0);
    check_tap("R9", 1'b0);

    // R1: single one walks the full chain to the tap (R6)
    step(1, 0, 1);
    for (int i = 1; i < N; i++) step(1, 0, 0);
    step(0, 1, 0);                       // R3 capture
    step(0, 0, 1);                       // R2 R4 idle with bit_in high
    step(1, 1, 0);                       // R5 both together
    step(1, 1, 1);
    for (int i = 0; i < N; i++) step(1, 0, i[0]);
    step(0, 1, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      step(r[0], r[1], r[2]);
    end

    // R7: chain clear is immediate, overrides shift, leaves holding register alone
    for (int i = 0; i < N; i++) step(1, 0, 1);
    step(0, 1, 0);
    @(negedge clk);
    chain_clr_n = 1'b0;
    #1;
    check_tap("R7", 1'b0);
    check_word("R7", m_word);
    adv_en = 1'b1; cap_en = 1'b0; bit_in = 1'b1;
    @(posedge clk); #1;
    check_tap("R7", 1'b0);
    check_word("R7", m_word);
    @(negedge clk);
    chain_clr_n = 1'b1; adv_en = 1'b0;
    m_chain = '0;
    step(0, 1, 0);                       // bring cleared chain out: R7

    // R8: holding clear is immediate, overrides capture, leaves chain alone
    for (int i = 0; i < N; i++) step(1, 0, 1);
    step(0, 1, 0);
    @(negedge clk);
    hold_clr_n = 1'b0;
    #1;
    check_word("R8", '0);
    cap_en = 1'b1; adv_en = 1'b0;
    @(posedge clk); #1;
    check_word("R8", '0);
    check_tap("R8", m_chain[N-1]);
    @(negedge clk);
    hold_clr_n = 1'b1; cap_en = 1'b0;
    m_word = '0;
    #1;
    check_word("R8", '0);
    step(0, 1, 0);                       // chain intact after holding clear: R8

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule